// File: doc/BRIEF.md
# PMIC Register Command Channel

This block sits between a host register bus and the engine that drives a power-management serial bus. Software uses it to issue one register read or one register write at a time. To write, the host first loads a data register and then writes a packed command word. The command word selects the opcode, the direction, the target slave, the transfer length minus one, and the target register address. The channel latches that word and presents it to the backend as a request, together with a snapshot of the data. The request stays up until the backend acknowledges it.

A write finishes as soon as the backend acknowledges it. A read finishes when the acknowledge arrives together with valid return data. The channel then captures the data and parks in a wait-for-valid-clear state. It stays there until software writes 1 to the ready register, which hands the channel back for the next command.

Software polls a status register to see the state machine value and a sticky overrun flag. The overrun flag records a command that arrived while the channel was busy and was therefore dropped. A separate register reflects whether the backend reports itself initialised.

Top module: `pmic_cmd_channel`

## Requirements
- R1: After reset the status register reads 0 (state IDLE, no overrun), the request output is low, and the read-data and write-data registers read 0.
- R2: A write to the command register in state IDLE is decoded as bits 31:30 opcode, bit 29 write flag (1 = write), bits 28:24 slave ID, bits 23:16 byte count minus one (0 = one byte) and bits 15:0 register address. On the next clock the request output is high, those fields appear on the backend outputs, and the status state field (bits 2:0) reads 1 (state encoding: IDLE=0, WAIT_BACKEND=1, WAIT_VALID_CLEAR=2).
- R3: The backend write data is the write-data register content at the moment the command was accepted. Later writes to the write-data register do not change a pending request.
- R4: The request and all of its fields stay asserted and unchanged until the backend acknowledges. A write command returns to IDLE on the clock that takes the acknowledge.
- R5: For a read command, an acknowledge with valid data moves the state to WAIT_VALID_CLEAR and captures the returned data into the read-data register. An acknowledge without valid data leaves the request pending.
- R6: Writing a word with bit 0 set to the ready register in WAIT_VALID_CLEAR returns the channel to IDLE, and the captured data stays readable.
- R7: A ready-register write has no effect if it arrives outside WAIT_VALID_CLEAR or if its bit 0 is 0.
- R8: A command write while the state is not IDLE is ignored, including one in the same clock as the completing acknowledge. It sets the sticky overrun flag, status bit 8. Writing a word with bit 8 set to the status register clears the flag.
- R9: Bit 0 of the init register follows the backend's init-done input one clock later.
- R10: Host word addresses are command 0, write data 1, read data 2, status 3, ready 4 and init 5. Reading the command address returns the latched command. Any other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | ADDR_W | Host word address |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Host read data of the addressed register |
| be_req | output | 1 | Backend request |
| be_opc | output | 2 | Command opcode |
| be_write | output | 1 | 1 = write transfer |
| be_slave | output | 5 | Slave ID |
| be_bcnt | output | 8 | Byte count minus one |
| be_addr | output | 16 | Target register address |
| be_wdata | output | DATA_W | Write data snapshot |
| be_ack | input | 1 | Backend acknowledge |
| be_rvalid | input | 1 | Read data valid with acknowledge |
| be_rdata | input | DATA_W | Returned read data |
| be_init_done | input | 1 | Backend initialised |

## Verification
Two events can land in the same clock: a host command write and the backend acknowledge that completes the previous command. The bench provokes this by raising the acknowledge and the command-register strobe in the same cycle while a write is pending. It then expects the state to be IDLE, the request to be low, the overrun flag to be set, and no new request to be launched. It judges the outcome at the status register and the request port, and confirms that the dropped command's fields never reach the backend.

// File: rtl/pmc_pkg.sv
`timescale 1ns/1ps
package pmc_pkg;
  localparam int CMD_W   = 32;
  localparam int OPC_W   = 2;
  localparam int SLV_W   = 5;
  localparam int BCNT_W  = 8;
  localparam int RADDR_W = 16;
  localparam int ST_W    = 3;
  localparam int OVR_BIT = 8;

  localparam int OFS_CMD   = 0;
  localparam int OFS_WDATA = 1;
  localparam int OFS_RDATA = 2;
  localparam int OFS_STAT  = 3;
  localparam int OFS_READY = 4;
  localparam int OFS_INIT  = 5;

  typedef enum logic [ST_W-1:0] {
    ST_IDLE     = 3'd0,
    ST_WAIT_BE  = 3'd1,
    ST_WAIT_CLR = 3'd2
  } chan_state_e;

  typedef struct packed {
    logic [OPC_W-1:0]   opc;
    logic               wr;
    logic [SLV_W-1:0]   slv;
    logic [BCNT_W-1:0]  bcnt;
    logic [RADDR_W-1:0] addr;
  } cmd_word_t;
endpackage

// File: rtl/pmc_rst_sync.sv
`timescale 1ns/1ps
module pmc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/pmc_chan_fsm.sv
`timescale 1ns/1ps
module pmc_chan_fsm
  import pmc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  cmd_word_t         cmd_in,
  input  logic [DATA_W-1:0] wdata_in,
  input  logic              rdy_wr,
  input  logic              be_ack,
  input  logic              be_rvalid,
  input  logic [DATA_W-1:0] be_rdata,
  output chan_state_e       state,
  output logic              be_req,
  output cmd_word_t         cmd_q,
  output logic [DATA_W-1:0] be_wdata,
  output logic [DATA_W-1:0] rdata_q
);
  chan_state_e       state_q, state_d;
  logic              cmd_en, cap_en;
  logic [DATA_W-1:0] wdq;

  always_comb begin
    state_d = state_q;
    cmd_en  = 1'b0;
    cap_en  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (cmd_wr) begin
          state_d = ST_WAIT_BE;
          cmd_en  = 1'b1;
        end
      end
      ST_WAIT_BE: begin
        if (be_ack) begin
          if (cmd_q.wr) begin
            state_d = ST_IDLE;
          end else if (be_rvalid) begin
            state_d = ST_WAIT_CLR;
            cap_en  = 1'b1;
          end
        end
      end
      ST_WAIT_CLR: begin
        if (rdy_wr) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
      wdq   <= '0;
    end else if (cmd_en) begin
      cmd_q <= cmd_in;
      wdq   <= wdata_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (cap_en) rdata_q <= be_rdata;
  end

  assign state    = state_q;
  assign be_req   = (state_q == ST_WAIT_BE);
  assign be_wdata = wdq;

  // R4: request held with stable fields until acknowledged
  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    be_req && !be_ack |=> be_req && $stable(cmd_q) && $stable(be_wdata));

  // R4: write completes on acknowledge
  p_write_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    be_req && be_ack && cmd_q.wr |=> state_q == ST_IDLE);

  // R5: read acknowledge with data captures and parks
  p_read_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    be_req && be_ack && be_rvalid && !cmd_q.wr
    |=> state_q == ST_WAIT_CLR && rdata_q == $past(be_rdata));

  // R6: ready write releases the parked read
  p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_WAIT_CLR && rdy_wr |=> state_q == ST_IDLE && $stable(rdata_q));

  // R7: without a ready write the channel stays parked
  p_park_r7: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_WAIT_CLR && !rdy_wr |=> state_q == ST_WAIT_CLR);
endmodule

// File: rtl/pmc_host_regs.sv
`timescale 1ns/1ps
module pmc_host_regs
  import pmc_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  input  chan_state_e       state,
  input  cmd_word_t         cmd_q,
  input  logic [DATA_W-1:0] rdata_q,
  input  logic              be_init_done,
  output logic              cmd_wr,
  output cmd_word_t         cmd_in,
  output logic [DATA_W-1:0] wdata_q,
  output logic              rdy_wr,
  output logic [DATA_W-1:0] host_rdata
);
  logic ovr_q, ovr_d, ovr_en;
  logic init_q;
  logic wdata_en, busy, stat_wr;

  assign busy     = (state != ST_IDLE);
  assign cmd_wr   = host_wr && (host_addr == ADDR_W'(OFS_CMD));
  assign wdata_en = host_wr && (host_addr == ADDR_W'(OFS_WDATA));
  assign stat_wr  = host_wr && (host_addr == ADDR_W'(OFS_STAT));
  assign rdy_wr   = host_wr && (host_addr == ADDR_W'(OFS_READY)) && host_wdata[0];
  assign cmd_in   = cmd_word_t'(host_wdata[CMD_W-1:0]);

  always_comb begin
    ovr_en = 1'b0;
    ovr_d  = ovr_q;
    if (cmd_wr && busy) begin
      ovr_en = 1'b1;
      ovr_d  = 1'b1;
    end else if (stat_wr && host_wdata[OVR_BIT]) begin
      ovr_en = 1'b1;
      ovr_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ovr_q <= 1'b0;
    else if (ovr_en) ovr_q <= ovr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        wdata_q <= '0;
    else if (wdata_en) wdata_q <= host_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) init_q <= 1'b0;
    else        init_q <= be_init_done;
  end

  always_comb begin
    host_rdata = '0;
    case (host_addr)
      ADDR_W'(OFS_CMD):   host_rdata[CMD_W-1:0] = cmd_q;
      ADDR_W'(OFS_WDATA): host_rdata = wdata_q;
      ADDR_W'(OFS_RDATA): host_rdata = rdata_q;
      ADDR_W'(OFS_STAT): begin
        host_rdata[ST_W-1:0] = state;
        host_rdata[OVR_BIT]  = ovr_q;
      end
      ADDR_W'(OFS_INIT):  host_rdata[0] = init_q;
      default:            host_rdata = '0;
    endcase
  end

  // R8: a command while busy raises the sticky overrun flag
  p_overrun_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && busy |=> ovr_q);

  // R8: the flag holds without a clearing write
  p_overrun_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_q && !stat_wr |=> ovr_q);
endmodule

// File: rtl/pmic_cmd_channel.sv
`timescale 1ns/1ps
module pmic_cmd_channel
  import pmc_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                host_wr,
  input  logic [ADDR_W-1:0]   host_addr,
  input  logic [DATA_W-1:0]   host_wdata,
  output logic [DATA_W-1:0]   host_rdata,
  output logic                be_req,
  output logic [OPC_W-1:0]    be_opc,
  output logic                be_write,
  output logic [SLV_W-1:0]    be_slave,
  output logic [BCNT_W-1:0]   be_bcnt,
  output logic [RADDR_W-1:0]  be_addr,
  output logic [DATA_W-1:0]   be_wdata,
  input  logic                be_ack,
  input  logic                be_rvalid,
  input  logic [DATA_W-1:0]   be_rdata,
  input  logic                be_init_done
);
  logic              rst_sync_n;
  logic              cmd_wr, rdy_wr;
  cmd_word_t         cmd_in, cmd_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  chan_state_e       state;

  pmc_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pmc_host_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .host_wr      (host_wr),
    .host_addr    (host_addr),
    .host_wdata   (host_wdata),
    .state        (state),
    .cmd_q        (cmd_q),
    .rdata_q      (rdata_q),
    .be_init_done (be_init_done),
    .cmd_wr       (cmd_wr),
    .cmd_in       (cmd_in),
    .wdata_q      (wdata_q),
    .rdy_wr       (rdy_wr),
    .host_rdata   (host_rdata)
  );

  pmc_chan_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cmd_wr    (cmd_wr),
    .cmd_in    (cmd_in),
    .wdata_in  (wdata_q),
    .rdy_wr    (rdy_wr),
    .be_ack    (be_ack),
    .be_rvalid (be_rvalid),
    .be_rdata  (be_rdata),
    .state     (state),
    .be_req    (be_req),
    .cmd_q     (cmd_q),
    .be_wdata  (be_wdata),
    .rdata_q   (rdata_q)
  );

  assign be_opc   = cmd_q.opc;
  assign be_write = cmd_q.wr;
  assign be_slave = cmd_q.slv;
  assign be_bcnt  = cmd_q.bcnt;
  assign be_addr  = cmd_q.addr;
endmodule

// File: tb/pmic_cmd_channel_test.sv
`timescale 1ns/1ps
module pmic_cmd_channel_test;
  localparam int AW = 3;
  localparam int DW = 32;
  localparam int NV = 6;

  // {command word, write data, backend return data}
  localparam logic [95:0] VEC [NV] = '{
    {2'd3, 1'b1, 5'd6,  8'd0, 16'h0408, 32'hA5A5_0001, 32'h0},
    {2'd3, 1'b0, 5'd6,  8'd0, 16'h0408, 32'h0,         32'h0000_00C3},
    {2'd0, 1'b1, 5'd31, 8'd3, 16'hFFFF, 32'hDEAD_BEEF, 32'h0},
    {2'd1, 1'b0, 5'd0,  8'd1, 16'h0000, 32'h0,         32'h1234_5678},
    {2'd2, 1'b0, 5'd17, 8'd255, 16'h8001, 32'h0,       32'hFFFF_FFFF},
    {2'd1, 1'b1, 5'd9,  8'd0, 16'h00F0, 32'h0000_0000, 32'h0}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          host_wr = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [DW-1:0] host_wdata = '0;
  logic [DW-1:0] host_rdata;
  logic          be_req, be_write;
  logic [1:0]    be_opc;
  logic [4:0]    be_slave;
  logic [7:0]    be_bcnt;
  logic [15:0]   be_addr;
  logic [DW-1:0] be_wdata;
  logic          be_ack = 1'b0, be_rvalid = 1'b0, be_init_done = 1'b0;
  logic [DW-1:0] be_rdata = '0;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  pmic_cmd_channel #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .be_req(be_req),
    .be_opc(be_opc), .be_write(be_write), .be_slave(be_slave),
    .be_bcnt(be_bcnt), .be_addr(be_addr), .be_wdata(be_wdata),
    .be_ack(be_ack), .be_rvalid(be_rvalid), .be_rdata(be_rdata),
    .be_init_done(be_init_done)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic hwrite(input int a, input logic [DW-1:0] d);
    @(negedge clk);
    host_addr = AW'(a); host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic hread(input int a, output logic [DW-1:0] d);
    host_addr = AW'(a);
    #0.5;
    d = host_rdata;
  endtask

  task automatic ack(input logic v, input logic [DW-1:0] d);
    @(negedge clk);
    be_ack = 1'b1; be_rvalid = v; be_rdata = d;
    @(negedge clk);
    be_ack = 1'b0; be_rvalid = 1'b0;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  function automatic logic [31:0] fields();
    return {be_opc, be_write, be_slave, be_bcnt, be_addr};
  endfunction

  initial begin
    repeat (40000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [DW-1:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    hread(3, r); check("R1 status", r, 0);
    check("R1 req", {31'b0, be_req}, 0);
    hread(2, r); check("R1 rdata", r, 0);
    hread(1, r); check("R1 wdata", r, 0);

    // R2 R4 R5 R6 vector walk
    for (int i = 0; i < NV; i++) begin
      logic [31:0] c, wd, rd;
      {c, wd, rd} = VEC[i];
      if (c[29]) hwrite(1, wd);
      hwrite(0, c);
      check("R2 req", {31'b0, be_req}, 1);
      check("R2 fields", fields(), c);
      hread(3, r); check("R2 state", r, 1);
      hread(0, r); check("R10 cmd readback", r, c);
      if (c[29]) begin
        check("R3 wdata", be_wdata, wd);
        ack(1'b0, 32'h0);
        hread(3, r); check("R4 write done", r, 0);
      end else begin
        ack(1'b1, rd);
        hread(3, r); check("R5 wait clear", r, 2);
        hread(2, r); check("R5 captured", r, rd);
        hwrite(4, 32'h1);
        hread(3, r); check("R6 released", r, 0);
        hread(2, r); check("R6 data kept", r, rd);
      end
    end

    // R3: snapshot survives later write-data updates; R4 hold without ack
    hwrite(1, 32'h1111_2222);
    hwrite(0, {2'd1, 1'b1, 5'd3, 8'd0, 16'h0042});
    hwrite(1, 32'h3333_4444);
    check("R3 snapshot", be_wdata, 32'h1111_2222);
    repeat (3) @(negedge clk);
    check("R4 held", {31'b0, be_req}, 1);
    check("R4 fields stable", fields(), {2'd1, 1'b1, 5'd3, 8'd0, 16'h0042});
    // R7: ready write while waiting on backend has no effect
    hwrite(4, 32'h1);
    hread(3, r); check("R7 ready in wait", r, 1);
    // R8: same-cycle command write and completing acknowledge
    @(negedge clk);
    host_addr = AW'(0); host_wdata = {2'd2, 1'b0, 5'd8, 8'd0, 16'h0777};
    host_wr = 1'b1; be_ack = 1'b1;
    @(negedge clk);
    host_wr = 1'b0; be_ack = 1'b0;
    hread(3, r); check("R8 coincident ignored", r, 32'h100);
    check("R8 no new req", {31'b0, be_req}, 0);
    @(negedge clk);
    check("R8 still no req", {31'b0, be_req}, 0);
    hwrite(3, 32'h100);
    hread(3, r); check("R8 clear", r, 0);

    // R5: read ack without valid keeps request
    hwrite(0, {2'd0, 1'b0, 5'd2, 8'd0, 16'h0010});
    ack(1'b0, 32'hBAD0_BAD0);
    hread(3, r); check("R5 no valid", r, 1);
    check("R5 req pending", {31'b0, be_req}, 1);
    hwrite(0, {2'd3, 1'b1, 5'd1, 8'd0, 16'h0001});
    hread(3, r); check("R8 busy overrun", r, 32'h101);
    check("R8 fields kept", fields(), {2'd0, 1'b0, 5'd2, 8'd0, 16'h0010});
    hwrite(3, 32'h0);
    hread(3, r); check("R8 clear needs bit8", r, 32'h101);
    ack(1'b1, 32'h0000_5A5A);
    // R7: ready write with bit0 clear in WAIT_VALID_CLEAR
    hwrite(4, 32'hFFFF_FFFE);
    hread(3, r); check("R7 bit0 clear", r, 32'h102);
    hwrite(4, 32'h1);
    hwrite(3, 32'h100);
    hread(3, r); check("R6 idle after ready", r, 0);
    // R7: ready write in IDLE
    hwrite(4, 32'h1);
    hread(3, r); check("R7 ready in idle", r, 0);
    hread(2, r); check("R7 rdata intact", r, 32'h0000_5A5A);

    // R9 init flag
    hread(5, r); check("R9 init low", r, 0);
    @(negedge clk); be_init_done = 1'b1;
    @(negedge clk);
    hread(5, r); check("R9 init high", r, 1);
    be_init_done = 1'b0;
    @(negedge clk);
    hread(5, r); check("R9 init drops", r, 0);

    // R10 unmapped
    hread(6, r); check("R10 unmapped 6", r, 0);
    hread(7, r); check("R10 unmapped 7", r, 0);

    finish_run();
  end
endmodule